// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits on a system bus as a slave and serves alias windows of 32 MB each. Every 32-bit word in an alias window stands for one single bit of a backing memory region. A read of an alias word returns that one bit in bit 0 of the read data. A write of an alias word sets or clears that one bit. The write is done as a read-modify-write on the backing memory, and it cannot be broken into by another master.

The default build has two bands. Alias window `0x2200_0000` maps onto backing base `0x2000_0000`. Alias window `0x4200_0000` maps onto backing base `0x4000_0000`. A strap input enables each band; a band that is not enabled claims no address. On the backing side the bridge issues plain reads and writes with a request/acknowledge handshake. It holds a lock flag for the whole of each read-modify-write. An error from the backing side is passed back to the requester.

Top module: `bitband_bridge`

## Requirements
- R1: An access hits only when its band is enabled and `s_addr[31:25]` equals that band's alias window (`0x22..` for band 0, `0x42..` for band 1). On a miss `s_hit` stays 0, no backing request is made and `s_ready` stays 0.
- R2: The backing address is the band's base ORed with `s_addr[24:0] >> 5`, then rounded down to the access size. `s_size` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and it is passed unchanged on `m_size`. `s_prot` is passed unchanged on `m_prot`.
- R3: The bit index is `(s_addr >> 2)` masked to (8·bytes − 1). Its upper bits choose a byte and its low 3 bits choose a bit in that byte. Backing data is right-justified and little-endian: the lowest-addressed byte is `m_rdata[7:0]`. A read returns the chosen bit in `s_rdata[0]`, with all other bits 0.
- R4: A write makes exactly one backing read and then one backing write to the same address and size. The chosen bit takes the value of `s_wdata[0]`, and every other bit of the fetched data is written back unchanged. `s_rdata` is 0 on a write.
- R5: `m_lock` is 1 for every request of a write's read-modify-write, from the read request through the write-back acknowledge. It is 0 on the requests of a plain read.
- R6: An error on the backing read gives `s_err` = 1 and `s_rdata` = 0, and no write-back is issued.
- R7: An error on the write-back gives `s_err` = 1.
- R8: Size code 3 is refused: `s_err` = 1, and no backing request is made.
- R9: After reset `s_ready`, `s_err`, `m_req` and `m_lock` are 0.
- R10: `s_ready` is a one-cycle pulse. Count clock edges from the edge that accepts the access, and let L be the number of wait cycles the backing side adds to each request. A read, or a write whose read fails, answers after 2+L edges. A write whose read succeeds answers after 4+2L edges. A refused size answers on the accepting edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| band_en | input | NUM_BANDS | Per-band enable strap |
| s_valid | input | 1 | Access request, held until `s_ready` |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Alias address |
| s_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2: 4 B, 3: refused) |
| s_wdata | input | 32 | Write data; bit 0 is the bit value |
| s_prot | input | 3 | Privilege/security attribute |
| s_hit | output | 1 | Address decodes to an enabled band |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result (bit 0 only) |
| s_err | output | 1 | Error response, valid with `s_ready` |
| m_req | output | 1 | Backing request, held until `m_ack` |
| m_write | output | 1 | Backing request is a write |
| m_lock | output | 1 | Backing access must not be interleaved |
| m_addr | output | 32 | Backing byte address, size-aligned |
| m_size | output | 2 | Backing access size code |
| m_prot | output | 3 | Attribute forwarded from the slave side |
| m_wdata | output | 32 | Write-back data, right-justified |
| m_ack | input | 1 | Backing acknowledge, one cycle |
| m_rdata | input | 32 | Backing read data, valid with `m_ack` |
| m_err | input | 1 | Backing error, valid with `m_ack` |

## Verification
When the bridge accepts an access, the driver notes the cycle number. It pushes the expected data, the expected error and the due cycle into the scoreboard: 2+L edges for reads and failed reads, 4+2L for full read-modify-writes, and 0 for refused sizes. The backing responder adds L wait cycles, with L set per test to 0, 1 or 2. On each falling edge the monitor samples `s_ready`. When it sees a response, it checks that the response came exactly on the due edge, so a response that is one cycle early or one cycle late counts as a miscompare. Misses are held for several cycles and then checked: `s_hit` must stay low, and no acknowledge and no response may appear.

// File: rtl/bitband_pkg.sv
// Package: shared types and helpers for the bit-band alias bridge.
// Assumes a 32-bit data path and the size code 0/1/2 = 1/2/4 bytes.
package bitband_pkg;

    localparam int WORD_BITS_LOG2 = 5;   // one alias word (4 bytes) per backing bit

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RESP = 2'd3
    } bb_state_e;

    localparam logic [1:0] SZ_BAD = 2'd3;

    // Low address bits that must be zero for an access of this size.
    function automatic logic [31:0] size_low_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_low_mask = 32'h0;
            2'd1:    size_low_mask = 32'h1;
            default: size_low_mask = 32'h3;
        endcase
    endfunction

    // Mask on the bit index: number of data bits of the access, minus one.
    function automatic logic [4:0] size_bit_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bit_mask = 5'd7;
            2'd1:    size_bit_mask = 5'd15;
            default: size_bit_mask = 5'd31;
        endcase
    endfunction

    // Data lanes that carry valid bytes for this size (right-justified).
    function automatic logic [31:0] size_lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_lane_mask = 32'h0000_00FF;
            2'd1:    size_lane_mask = 32'h0000_FFFF;
            default: size_lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bitband_decode.sv
// Module: bitband_decode
// Matches the alias address against every enabled band and forms the
// unaligned backing byte address of the band that matches.
// Assumes the alias windows do not overlap and are aligned to 2**WIN_BITS.
module bitband_decode #(
    parameter int NUM_BANDS = 2,
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 25,
    parameter logic [NUM_BANDS*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_BANDS*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [NUM_BANDS-1:0] band_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [ADDR_W-1:0]    back_addr
);
    import bitband_pkg::*;

    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [NUM_BANDS-1:0] match;
    logic [ADDR_W-1:0]    cand [NUM_BANDS];

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        // Per-band window match and candidate backing address.
        assign match[g] = band_en[g] &&
            (addr[ADDR_W-1:WIN_BITS] == ALIAS_BASES[g*ADDR_W+WIN_BITS +: TAG_W]);
        assign cand[g]  = BACK_BASES[g*ADDR_W +: ADDR_W] |
            ADDR_W'(addr[WIN_BITS-1:0] >> WORD_BITS_LOG2);
    end

    // Merge the matching band's address; at most one band matches.
    always_comb begin
        back_addr = '0;
        for (int i = 0; i < NUM_BANDS; i++) begin
            if (match[i]) back_addr = back_addr | cand[i];
        end
        hit = |match;
    end

endmodule

// File: rtl/bitband_bitops.sv
// Module: bitband_bitops
// Pulls the selected bit out of fetched backing data and builds the
// write-back word with that bit replaced. Data is right-justified and
// little-endian: byte index 0 is the lowest-addressed byte.
// Assumes the size code is 0, 1 or 2.
module bitband_bitops #(
    parameter int DATA_W = 32,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [BIT_W-1:0]  bitpos,
    input  logic [1:0]        size,
    input  logic              wbit,
    output logic              rbit,
    output logic [DATA_W-1:0] new_word
);
    import bitband_pkg::*;

    logic [DATA_W-1:0] kept;
    logic [7:0]        sel_byte;

    // Keep only the lanes of this size; split the index into byte and bit.
    always_comb begin
        kept     = rdata & size_lane_mask(size);
        sel_byte = kept[{bitpos[BIT_W-1:3], 3'b000} +: 8];
        rbit     = sel_byte[bitpos[2:0]];
    end

    // Replace the selected bit, leaving every other kept bit unchanged.
    always_comb begin
        new_word         = kept;
        new_word[bitpos] = wbit;
    end

endmodule

// File: rtl/bitband_seq.sv
// Module: bitband_seq
// Controls one alias access: it captures the request, issues the backing
// read, and for writes issues the locked write-back, then answers with a
// one-cycle ready pulse. Assumes the requester holds s_valid and its fields
// until s_ready, and that the backing side answers each request with a
// single m_ack.
module bitband_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic              s_hit,
    input  logic              s_write,
    input  logic [1:0]        s_size,
    input  logic [2:0]        s_prot,
    input  logic              s_wbit,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BIT_W-1:0]  in_bitpos,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_err,
    output logic              m_req,
    output logic              m_write,
    output logic              m_lock,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [2:0]        m_prot,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ack,
    input  logic              m_err,
    output logic [BIT_W-1:0]  cur_bitpos,
    output logic              cur_wbit,
    input  logic              rbit,
    input  logic [DATA_W-1:0] new_word
);
    import bitband_pkg::*;

    bb_state_e         state;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        cur_size;
    logic [2:0]        cur_prot;
    logic [DATA_W-1:0] wb_data;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_err;

    // Access sequencing: capture, read, optional write-back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_write  <= 1'b0;
            cur_addr   <= '0;
            cur_size   <= '0;
            cur_prot   <= '0;
            cur_bitpos <= '0;
            cur_wbit   <= 1'b0;
            wb_data    <= '0;
            rsp_data   <= '0;
            rsp_err    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (s_valid && s_hit) begin
                        cur_write  <= s_write;
                        cur_addr   <= in_addr;
                        cur_size   <= s_size;
                        cur_prot   <= s_prot;
                        cur_bitpos <= in_bitpos;
                        cur_wbit   <= s_wbit;
                        rsp_data   <= '0;
                        if (s_size == SZ_BAD) begin
                            rsp_err <= 1'b1;
                            state   <= ST_RESP;
                        end else begin
                            rsp_err <= 1'b0;
                            state   <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (m_ack) begin
                        if (m_err) begin
                            rsp_err <= 1'b1;
                            state   <= ST_RESP;
                        end else if (cur_write) begin
                            wb_data <= new_word;
                            state   <= ST_WR;
                        end else begin
                            rsp_data <= DATA_W'(rbit);
                            state    <= ST_RESP;
                        end
                    end
                end
                ST_WR: begin
                    if (m_ack) begin
                        rsp_err <= m_err;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the state and the captured access fields.
    always_comb begin
        m_req   = (state == ST_RD) || (state == ST_WR);
        m_write = (state == ST_WR);
        m_lock  = ((state == ST_RD) && cur_write) || (state == ST_WR);
        m_addr  = cur_addr;
        m_size  = cur_size;
        m_prot  = cur_prot;
        m_wdata = wb_data;
        s_ready = (state == ST_RESP);
        s_rdata = rsp_data;
        s_err   = rsp_err;
    end

    // A clean locked read must be followed at once by the locked write-back.
    p_rmw_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack && m_req && !m_write && m_lock && !m_err) |=> (m_req && m_write && m_lock));

    // A failed backing read ends the access with no further request.
    p_no_wb_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack && m_req && !m_write && m_err) |=> (!m_req && s_ready && s_err));

    // A pending backing request keeps its address and direction.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_write)));

    // A refused size answers at once with an error and no backing request.
    p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && !s_ready && s_valid && s_hit && s_size == SZ_BAD) |=> (s_ready && s_err && !m_req));

    // The ready pulse lasts a single cycle.
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

endmodule

// File: rtl/bitband_bridge.sv
// Module: bitband_bridge (top)
// Bit-band alias bridge: decodes the alias window, forms the aligned
// backing address and bit index, and runs the read or the locked
// read-modify-write on the backing port. Assumes one outstanding access
// and a backing side that keeps the lock honoured.
module bitband_bridge #(
    parameter int NUM_BANDS = 2,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WIN_BITS  = 25,
    parameter logic [NUM_BANDS*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_BANDS*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANDS-1:0] band_en,
    input  logic                 s_valid,
    input  logic                 s_write,
    input  logic [ADDR_W-1:0]    s_addr,
    input  logic [1:0]           s_size,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [2:0]           s_prot,
    output logic                 s_hit,
    output logic                 s_ready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic                 s_err,
    output logic                 m_req,
    output logic                 m_write,
    output logic                 m_lock,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [1:0]           m_size,
    output logic [2:0]           m_prot,
    output logic [DATA_W-1:0]    m_wdata,
    input  logic                 m_ack,
    input  logic [DATA_W-1:0]    m_rdata,
    input  logic                 m_err
);
    import bitband_pkg::*;

    localparam int BIT_W = $clog2(DATA_W);

    logic [ADDR_W-1:0] raw_addr;
    logic [ADDR_W-1:0] aligned_addr;
    logic [BIT_W-1:0]  bitpos;
    logic [BIT_W-1:0]  cur_bitpos;
    logic              cur_wbit;
    logic              rbit;
    logic [DATA_W-1:0] new_word;
    logic              unused_bits;

    assign unused_bits = ^{s_wdata[DATA_W-1:1], s_addr[1:0]};

    bitband_decode #(
        .NUM_BANDS  (NUM_BANDS),
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .ALIAS_BASES(ALIAS_BASES),
        .BACK_BASES (BACK_BASES)
    ) u_decode (
        .band_en  (band_en),
        .addr     (s_addr),
        .hit      (s_hit),
        .back_addr(raw_addr)
    );

    // Size alignment of the backing address and the in-access bit index.
    always_comb begin
        aligned_addr = raw_addr & ~ADDR_W'(size_low_mask(s_size));
        bitpos       = s_addr[BIT_W+1:2] & BIT_W'(size_bit_mask(s_size));
    end

    bitband_bitops #(.DATA_W(DATA_W)) u_bitops (
        .rdata   (m_rdata),
        .bitpos  (cur_bitpos),
        .size    (m_size),
        .wbit    (cur_wbit),
        .rbit    (rbit),
        .new_word(new_word)
    );

    bitband_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_hit     (s_hit),
        .s_write   (s_write),
        .s_size    (s_size),
        .s_prot    (s_prot),
        .s_wbit    (s_wdata[0]),
        .in_addr   (aligned_addr),
        .in_bitpos (bitpos),
        .s_ready   (s_ready),
        .s_rdata   (s_rdata),
        .s_err     (s_err),
        .m_req     (m_req),
        .m_write   (m_write),
        .m_lock    (m_lock),
        .m_addr    (m_addr),
        .m_size    (m_size),
        .m_prot    (m_prot),
        .m_wdata   (m_wdata),
        .m_ack     (m_ack),
        .m_err     (m_err),
        .cur_bitpos(cur_bitpos),
        .cur_wbit  (cur_wbit),
        .rbit      (rbit),
        .new_word  (new_word)
    );

    // Every backing request is aligned to its own size.
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_addr & ADDR_W'(size_low_mask(m_size))) == '0));

    // A read answer carries nothing above bit 0.
    p_rdata_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (s_rdata[DATA_W-1:1] == '0));

    // A request that decodes nowhere never starts a backing access.
    p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && !s_ready && !s_hit) |=> !m_req);

endmodule

// File: tb/bitband_bridge_test.sv
// Scoreboard bench for bitband_bridge: the driver pushes expected responses,
// the monitor pops and compares them on each response, and a responder
// models backing memory with a set wait count and error injection.
module bitband_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  band_en = 2'b11;
    logic        s_valid = 1'b0;
    logic        s_write = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic [31:0] s_wdata = '0;
    logic [2:0]  s_prot = '0;
    logic        s_hit, s_ready, s_err;
    logic [31:0] s_rdata;
    logic        m_req, m_write, m_lock;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [2:0]  m_prot;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;

    always #5 clk = ~clk;

    bitband_bridge uut (
        .clk(clk), .rst_n(rst_n), .band_en(band_en),
        .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr), .s_size(s_size),
        .s_wdata(s_wdata), .s_prot(s_prot), .s_hit(s_hit), .s_ready(s_ready),
        .s_rdata(s_rdata), .s_err(s_err), .m_req(m_req), .m_write(m_write),
        .m_lock(m_lock), .m_addr(m_addr), .m_size(m_size), .m_prot(m_prot),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err)
    );

    typedef struct {
        logic [31:0] data;
        logic        err;
        int          due;
        int          start;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fails = 0;
    int          cyc = 0;
    int          lat_cfg = 0;
    int          wait_cnt = 0;
    int          ack_count = 0;
    int          lock_viol = 0;
    bit          op_wr = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    bit          err_rd_on = 0;
    bit          err_wr_on = 0;
    logic [31:0] rd_addr_log = '0;
    logic [2:0]  prot_log = '0;
    logic [1:0]  size_log = '0;
    logic [7:0]  bus_mem [int unsigned];
    logic [7:0]  ref_mem [int unsigned];
    logic [31:0] asm_w;
    logic        hit_err;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] bus_byte(input logic [31:0] a);
        return bus_mem.exists(a) ? bus_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Backing memory responder with wait cycles and error injection.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
            wait_cnt <= 0;
            for (int i = 0; i < 64; i++) begin
                bus_mem[32'h2000_0000 + i] = 8'(i * 37 + 5);
                bus_mem[32'h4000_0000 + i] = 8'(i * 91 + 3);
            end
        end else begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
            if (m_req && !m_ack) begin
                if (wait_cnt >= lat_cfg) begin
                    wait_cnt <= 0;
                    m_ack <= 1'b1;
                    ack_count <= ack_count + 1;
                    hit_err = (m_addr == err_addr) && (m_write ? err_wr_on : err_rd_on);
                    m_err <= hit_err;
                    if (m_write) begin
                        if (!hit_err)
                            for (int k = 0; k < (1 << m_size); k++)
                                bus_mem[m_addr + k] = m_wdata[8*k +: 8];
                    end else begin
                        asm_w = '0;
                        for (int k = 0; k < (1 << m_size); k++)
                            asm_w[8*k +: 8] = bus_byte(m_addr + k);
                        m_rdata <= asm_w;
                        rd_addr_log <= m_addr;
                        prot_log <= m_prot;
                        size_log <= m_size;
                    end
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    // Lock watcher: writes' requests locked, plain reads unlocked (R5).
    always @(negedge clk) begin
        if (rst_n && m_req) begin
            if (m_write && !m_lock) lock_viol++;
            if (!m_write && op_wr && !m_lock) lock_viol++;
            if (!m_write && !op_wr && m_lock) lock_viol++;
        end
    end

    // Scoreboard monitor: pop and compare on each ready pulse.
    always @(negedge clk) begin
        if (rst_n && s_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "response with nothing pending", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(s_err == e.err, e.req, "s_err", 32'(s_err), 32'(e.err));
                check(s_rdata == e.data, e.req, "s_rdata", s_rdata, e.data);
                check(cyc - e.start == e.due, "R10", "response cycle",
                      32'(cyc - e.start), 32'(e.due));
            end
        end
    end

    // Driver: compute the expected result, push it, run the access.
    task automatic run_op(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                          input bit wv, input int lat, input logic [2:0] prot,
                          input string req);
        logic [31:0] base, off, back, byte_a;
        int          n, bp, acks0;
        bit          bad, rd_fail, wb_fail;
        exp_t        e;
        base = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
        off  = a & 32'h01FF_FFFF;
        n    = (sz == 2'd3) ? 4 : (1 << sz);
        back = (base | (off >> 5)) & ~32'(n - 1);
        bp   = int'((off >> 2) & 32'(8 * n - 1));
        byte_a = back + 32'(bp / 8);
        bad     = (sz == 2'd3);
        rd_fail = !bad && err_rd_on && (back == err_addr);
        wb_fail = !bad && !rd_fail && wr && err_wr_on && (back == err_addr);
        e.err   = bad || rd_fail || wb_fail;
        e.data  = (!wr && !e.err) ? 32'(ref_byte(byte_a)[bp % 8]) : 32'h0;
        e.due   = bad ? 0 : ((wr && !rd_fail) ? 4 + 2 * lat : 2 + lat);
        e.req   = req;
        if (wr && !e.err) begin
            logic [7:0] b;
            b = ref_byte(byte_a);
            b[bp % 8] = wv;
            ref_mem[byte_a] = b;
        end
        @(negedge clk);
        lat_cfg = lat;
        op_wr   = wr;
        acks0   = ack_count;
        s_valid = 1'b1;
        s_write = wr;
        s_addr  = a;
        s_size  = sz;
        s_wdata = {31'h2AAA_AAAA, wv};
        s_prot  = prot;
        e.start = cyc + 1;
        sb.push_back(e);
        do @(negedge clk); while (!s_ready);
        s_valid = 1'b0;
        if (bad) begin
            check(ack_count == acks0, "R8", "backing accesses", 32'(ack_count - acks0), 32'd0);
        end else begin
            check(rd_addr_log == back, "R2", "backing address", rd_addr_log, back);
            check(prot_log == prot && size_log == sz, "R2", "forwarded prot/size",
                  {prot_log, size_log}, {prot, sz});
            check(ack_count - acks0 == ((wr && !rd_fail) ? 2 : 1),
                  rd_fail ? "R6" : "R4", "backing access count",
                  32'(ack_count - acks0), 32'((wr && !rd_fail) ? 2 : 1));
        end
        if (wr && !bad) begin
            for (int k = 0; k < n; k++)
                check(bus_byte(back + 32'(k)) == ref_byte(back + 32'(k)),
                      e.err ? "R7" : "R4", "backing byte after write",
                      32'(bus_byte(back + 32'(k))), 32'(ref_byte(back + 32'(k))));
        end
        check(lock_viol == 0, "R5", "lock violations", 32'(lock_viol), 32'd0);
    endtask

    // Miss: hold the request and expect no hit, no access and no response.
    task automatic miss_op(input logic [31:0] a, input string req);
        int  acks0;
        bit  hit_seen;
        hit_seen = 0;
        @(negedge clk);
        acks0   = ack_count;
        s_valid = 1'b1;
        s_write = 1'b0;
        s_addr  = a;
        s_size  = 2'd2;
        repeat (6) begin
            @(negedge clk);
            if (s_hit || s_ready) hit_seen = 1;
        end
        s_valid = 1'b0;
        check(!hit_seen, req, "hit or response on miss", 32'(hit_seen), 32'd0);
        check(ack_count == acks0, req, "backing access on miss", 32'(ack_count - acks0), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref_mem[32'h2000_0000 + i] = 8'(i * 37 + 5);
            ref_mem[32'h4000_0000 + i] = 8'(i * 91 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check(!s_ready && !s_err && !m_req && !m_lock, "R9", "reset outputs",
              {28'h0, s_ready, s_err, m_req, m_lock}, 32'h0);

        // R3: word reads, band 0 and band 1, several wait counts
        run_op(0, 32'h2200_0084, 2'd2, 0, 0, 3'd1, "R3");
        run_op(0, 32'h2200_01FC, 2'd2, 0, 1, 3'd2, "R3");
        run_op(0, 32'h4200_0344, 2'd2, 0, 2, 3'd5, "R3");
        // R3: every bit of one byte with byte reads
        for (int b = 0; b < 8; b++)
            run_op(0, 32'h2200_0000 + 32'((5 * 8 + b) * 4), 2'd0, 0, b % 3, 3'd0, "R3");
        // R3: halfword reads, both bytes of the half
        run_op(0, 32'h4200_0000 + 32'((7 * 8 + 3) * 4), 2'd1, 0, 1, 3'd3, "R3");
        run_op(0, 32'h4200_0000 + 32'((6 * 8 + 6) * 4), 2'd1, 0, 0, 3'd3, "R3");

        // R4: set and clear with each size, then read back
        run_op(1, 32'h2200_0000 + 32'((9 * 8 + 4) * 4), 2'd2, 1, 0, 3'd4, "R4");
        run_op(0, 32'h2200_0000 + 32'((9 * 8 + 4) * 4), 2'd2, 0, 0, 3'd4, "R4");
        run_op(1, 32'h2200_0000 + 32'((2 * 8 + 0) * 4), 2'd0, 0, 1, 3'd0, "R4");
        run_op(1, 32'h2200_0000 + 32'((2 * 8 + 1) * 4), 2'd0, 1, 2, 3'd0, "R4");
        run_op(0, 32'h2200_0000 + 32'((2 * 8 + 1) * 4), 2'd0, 0, 0, 3'd0, "R4");
        run_op(1, 32'h4200_0000 + 32'((11 * 8 + 7) * 4), 2'd1, 0, 1, 3'd6, "R4");
        run_op(1, 32'h4200_0000 + 32'((11 * 8 + 7) * 4), 2'd1, 1, 0, 3'd6, "R4");
        run_op(0, 32'h4200_0000 + 32'((11 * 8 + 7) * 4), 2'd0, 0, 2, 3'd6, "R4");

        // R1: disabled band and out-of-window address
        band_en = 2'b01;
        miss_op(32'h4200_0010, "R1");
        run_op(0, 32'h2200_0010, 2'd2, 0, 0, 3'd0, "R1");
        band_en = 2'b11;
        miss_op(32'h2400_0000, "R1");
        miss_op(32'h2000_0040, "R1");

        // R8: refused size
        run_op(0, 32'h2200_0020, 2'd3, 0, 0, 3'd0, "R8");
        run_op(1, 32'h4200_0020, 2'd3, 1, 0, 3'd0, "R8");

        // R6: backing read error on a read and on a write
        err_addr = 32'h2000_0010; err_rd_on = 1;
        run_op(0, 32'h2200_0000 + 32'((16 * 8 + 2) * 4), 2'd2, 0, 1, 3'd0, "R6");
        run_op(1, 32'h2200_0000 + 32'((16 * 8 + 2) * 4), 2'd2, 1, 0, 3'd0, "R6");
        err_rd_on = 0;

        // R7: write-back error leaves memory unchanged
        err_addr = 32'h4000_0020; err_wr_on = 1;
        run_op(1, 32'h4200_0000 + 32'((32 * 8 + 5) * 4), 2'd0, 1, 1, 3'd0, "R7");
        err_wr_on = 0;
        run_op(0, 32'h4200_0000 + 32'((32 * 8 + 5) * 4), 2'd0, 0, 0, 3'd0, "R7");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10", "responses outstanding", 32'(sb.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule